// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder

This block turns the 4-bit transmit nibbles of a 100 Mb/s twisted-pair port into the three-level line code that drives the cable. At every code-group boundary a small controller picks the next 5-bit group: idle fill between frames, a start delimiter pair when a frame begins, one mapped group for each data nibble, and an end delimiter pair when transmit-enable drops. The group is shifted out one bit per enabled clock, most significant bit first.

Each serial bit is whitened by an 11-bit additive stream cipher, NRZI coded and then MLT-3 coded onto a 2-bit signed level. The cipher register is seeded during reset from the port's address, so two ports with different addresses put different sequences on their cables. A bit-rate enable lets the block run from a faster clock. When the enable is low, every stage holds its state.

Top module: `fetx_encoder`

## Requirements
- R1: While `rstN` is low, and on the first falling edge after it rises, `mltLevel` is 2'b00 and `nibbleAck` is 0, whatever `txEn` is doing.
- R2: While `txEn` is low outside a frame, the idle group 5'b11111 is sent again and again. The first group after reset is idle.
- R3: If `txEn` is high at a group boundary while idle, the next two groups are J (5'b11000) and then K (5'b10001). The first data nibble is sampled at the boundary where K ends.
- R4: Data nibbles map to groups as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: If `txEn` is low at a boundary where a data group is pending, the next groups are T (5'b01101) and then R (5'b00111). `txEn` is ignored at the R boundary and at the boundary after it, so at least one idle group comes before the next J.
- R6: Group bits leave bit 4 first. One bit is sent per enabled cycle, and a boundary occurs every five enabled cycles.
- R7: On each enabled cycle, key = s[10]^s[8]. The scrambled bit is the plain bit XOR key, and then s ← {s[9:0], key}.
- R8: In reset the cipher register is loaded with {phyAddr, ~phyAddr, 1'b1}. Bit 0 is set, so the register is never zero, and different addresses give different line sequences.
- R9: The NRZI state toggles on each enabled cycle whose scrambled bit is 1. It changes on no other cycle.
- R10: The MLT-3 phase steps 0, +1, 0, -1 once for each NRZI transition, one enabled cycle after that transition. The level codes are 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. 2'b10 never appears.
- R11: On a clock where `bitEn` is low, `mltLevel`, the group position, the cipher state and the line state do not change.
- R12: `nibbleAck` is high only in the cycle whose rising edge samples `txData` for a data group. It pulses once per nibble, and `txData` at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rstN | input | 1 | Synchronous active-low reset; loads the cipher seed |
| bitEn | input | 1 | Bit-rate enable; one line bit per high cycle |
| phyAddr | input | 5 | Port address that selects the cipher seed |
| txEn | input | 1 | Transmit enable from the MAC side |
| txData | input | 4 | Transmit nibble |
| nibbleAck | output | 1 | High in the cycle whose edge takes `txData` |
| mltLevel | output | 2 | Signed MLT-3 level: 00 zero, 01 plus, 11 minus |

## Verification
Each plain bit reaches `mltLevel` two enabled edges after the edge where it is the serial bit: the NRZI register takes it on the first of these edges and the MLT-3 phase follows on the next. `nibbleAck` is combinational and is valid during the cycle before its sampling edge. The bench keeps a model of the group stream, cipher, NRZI and MLT-3 state that advances on the same enabled rising edges. It compares against that model at every falling edge, so each comparison falls between two edges. Stimulus changes only at falling edges, and the bench drives the next nibble only after the edge that took the current one.

// File: rtl/fetx_pkg.sv
package fetx_pkg;
  parameter int NIB_W    = 4;
  parameter int GRP_W    = 5;
  parameter int ADDR_W   = 5;
  parameter int LFSR_W   = 2 * ADDR_W + 1;
  parameter int LFSR_TAP = 9;
  parameter int LVL_W    = 2;

  typedef enum logic [2:0] {
    GRP_I, GRP_J, GRP_K, GRP_D, GRP_T, GRP_R
  } grp_e;

  typedef struct packed {
    logic adv;   // advance one line bit
    logic load;  // boundary: load the selected group
    grp_e sel;   // group to load on a boundary
  } strobe_t;

  localparam logic [GRP_W-1:0] CODE_I = 5'b11111;
  localparam logic [GRP_W-1:0] CODE_J = 5'b11000;
  localparam logic [GRP_W-1:0] CODE_K = 5'b10001;
  localparam logic [GRP_W-1:0] CODE_T = 5'b01101;
  localparam logic [GRP_W-1:0] CODE_R = 5'b00111;

  function automatic logic [GRP_W-1:0] dataCode(input logic [NIB_W-1:0] nib);
    logic [GRP_W-1:0] c;
    case (nib)
      4'h0: c = 5'b11110;  4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;  4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;  4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;  4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;  4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;  4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;  4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;  default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic logic [GRP_W-1:0] groupCode(input grp_e sel,
                                                 input logic [NIB_W-1:0] nib);
    logic [GRP_W-1:0] c;
    case (sel)
      GRP_J:   c = CODE_J;
      GRP_K:   c = CODE_K;
      GRP_D:   c = dataCode(nib);
      GRP_T:   c = CODE_T;
      GRP_R:   c = CODE_R;
      default: c = CODE_I;
    endcase
    return c;
  endfunction

  function automatic logic [LFSR_W-1:0] seedOf(input logic [ADDR_W-1:0] addr);
    return {addr, ~addr, 1'b1};
  endfunction
endpackage

// File: rtl/fetx_ctrl.sv
module fetx_ctrl
  import fetx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  input  logic    txEn,
  output strobe_t strb,
  output logic    nibbleAck
);
  localparam int CNT_W = $clog2(GRP_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(GRP_W - 1);

  logic [CNT_W-1:0] bitCnt;
  grp_e             curGrp;
  grp_e             nextGrp;
  logic             boundary;

  assign boundary = bitEn && (bitCnt == LAST_POS);

  always_comb begin
    case (curGrp)
      GRP_I:          nextGrp = txEn ? GRP_J : GRP_I;
      GRP_J:          nextGrp = GRP_K;
      GRP_K, GRP_D:   nextGrp = txEn ? GRP_D : GRP_T;
      GRP_T:          nextGrp = GRP_R;
      default:        nextGrp = GRP_I;
    endcase
  end

  assign nibbleAck = boundary && (nextGrp == GRP_D);

  always_comb begin
    strb.adv  = bitEn;
    strb.load = boundary;
    strb.sel  = nextGrp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      curGrp <= GRP_I;
    end else if (bitEn) begin
      if (boundary) begin
        bitCnt <= '0;
        curGrp <= nextGrp;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R11
  ctrl_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(bitCnt) && $stable(curGrp)));

  // R12
  ack_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    nibbleAck |-> bitEn);

  // R5
  idle_before_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(curGrp == GRP_J) |-> ($past(curGrp) == GRP_I));

  // R3
  k_after_j_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(curGrp == GRP_J) |-> (curGrp == GRP_K));
endmodule

// File: rtl/fetx_dpath.sv
module fetx_dpath
  import fetx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [NIB_W-1:0]  txData,
  input  logic [ADDR_W-1:0] phyAddr,
  output logic [LVL_W-1:0]  mltLevel
);
  logic [GRP_W-1:0]  shReg;
  logic [LFSR_W-1:0] lfsr;
  logic              keyBit;
  logic              scrBit;
  logic              nrziQ;
  logic              nrziD;
  logic [1:0]        phase;

  assign keyBit = lfsr[LFSR_W-1] ^ lfsr[LFSR_TAP-1];
  assign scrBit = shReg[GRP_W-1] ^ keyBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= CODE_I;
      lfsr  <= seedOf(phyAddr);
      nrziQ <= 1'b0;
      nrziD <= 1'b0;
      phase <= '0;
    end else if (strb.adv) begin
      if (strb.load) shReg <= groupCode(strb.sel, txData);
      else           shReg <= {shReg[GRP_W-2:0], 1'b0};
      lfsr  <= {lfsr[LFSR_W-2:0], keyBit};
      nrziQ <= nrziQ ^ scrBit;
      nrziD <= nrziQ;
      if (nrziQ != nrziD) phase <= phase + 2'd1;
    end
  end

  always_comb begin
    case (phase)
      2'd1:    mltLevel = 2'b01;
      2'd3:    mltLevel = 2'b11;
      default: mltLevel = 2'b00;
    endcase
  end

  // R11
  line_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.adv |=> ($stable(mltLevel) && $stable(lfsr) && $stable(shReg)));

  // R8
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

  // R10
  mlt_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    mltLevel != 2'b10);

  // R10
  mlt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mltLevel) |-> (mltLevel == 2'b00 || $past(mltLevel) == 2'b00));

  // R9
  nrzi_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(nrziQ) |-> $past(strb.adv));
endmodule

// File: rtl/fetx_encoder.sv
module fetx_encoder
  import fetx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic              txEn,
  input  logic [NIB_W-1:0]  txData,
  output logic              nibbleAck,
  output logic [LVL_W-1:0]  mltLevel
);
  strobe_t strb;

  fetx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .txEn      (txEn),
    .strb      (strb),
    .nibbleAck (nibbleAck)
  );

  fetx_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .txData   (txData),
    .phyAddr  (phyAddr),
    .mltLevel (mltLevel)
  );
endmodule

// File: tb/tb_fetx_encoder.sv
module tb_fetx_encoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b1;
  logic       txEn = 1'b0;
  logic [4:0] phyAddr = 5'd0;
  logic [3:0] txData = 4'd0;
  logic       nibbleAck;
  logic [1:0] mltLevel;

  always #4 clk = ~clk;

  fetx_encoder dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .phyAddr(phyAddr),
    .txEn(txEn), .txData(txData), .nibbleAck(nibbleAck), .mltLevel(mltLevel)
  );

  int checks = 0, errors = 0;
  int mism = 0, stallErr = 0, ackCnt = 0, enMode = 0;

  localparam logic [4:0] B_I = 5'b11111, B_J = 5'b11000, B_K = 5'b10001,
                         B_T = 5'b01101, B_R = 5'b00111;
  localparam logic [4:0] TBL [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                      5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                      5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                      5'b11010, 5'b11011, 5'b11100, 5'b11101};

  // reference model of the line
  logic [4:0]  expQ [$];
  logic [4:0]  mGrp;
  int          mPos;
  logic [10:0] mLfsr;
  logic        mNrzi, mNrziD, mBit, mKey;
  logic [1:0]  mPhase;
  logic        lastEn = 1'b1;
  logic [1:0]  lastMlt = 2'b00;

  function automatic logic [1:0] lvlOf(input logic [1:0] p);
    return (p == 2'd1) ? 2'b01 : (p == 2'd3) ? 2'b11 : 2'b00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mGrp = B_I; mPos = 0; mLfsr = {phyAddr, ~phyAddr, 1'b1};
      mNrzi = 1'b0; mNrziD = 1'b0; mPhase = 2'd0;
    end else if (bitEn) begin
      mBit  = mGrp[4-mPos];
      mKey  = mLfsr[10] ^ mLfsr[8];
      mLfsr = {mLfsr[9:0], mKey};
      if (mNrzi != mNrziD) mPhase = mPhase + 2'd1;
      mNrziD = mNrzi;
      mNrzi  = mNrzi ^ (mBit ^ mKey);
      if (mPos == 4) begin
        mPos = 0;
        mGrp = (expQ.size() > 0) ? expQ.pop_front() : B_I;
      end else mPos++;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (mltLevel !== lvlOf(mPhase)) mism++;
      if (!lastEn && mltLevel !== lastMlt) stallErr++;
      if (nibbleAck) ackCnt++;
    end
    lastEn  = bitEn;
    lastMlt = mltLevel;
  end

  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      k++;
      bitEn <= (enMode == 0) ? 1'b1 : ((k % 3) != 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [4:0] addr);
    rstN = 1'b0; txEn = 1'b0; phyAddr = addr; expQ.delete();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [3:0] nibOf(input int base, input int step, input int i);
    return 4'((base + i * step) & 15);
  endfunction

  task automatic sendFrame(input int n, input int base, input int step,
                           input bit leadIdle, input bit junk);
    if (leadIdle) expQ.push_back(B_I);
    expQ.push_back(B_J);
    expQ.push_back(B_K);
    for (int i = 0; i < n; i++) expQ.push_back(TBL[nibOf(base, step, i)]);
    expQ.push_back(B_T);
    expQ.push_back(B_R);
    txEn = 1'b1;
    txData = nibOf(base, step, 0);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!nibbleAck);
      @(posedge clk);
      @(negedge clk);
      if (i < n - 1) begin
        if (junk) begin
          txData = ~nibOf(base, step, i + 1);
          @(negedge clk);
        end
        txData = nibOf(base, step, i + 1);
      end else txEn = 1'b0;
    end
  endtask

  task automatic waitBoundary();
    do @(negedge clk); while (!(bitEn && mPos == 4));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0; txEn = 1'b1; phyAddr = 5'h03; expQ.delete();
    repeat (4) @(negedge clk);
    chk(mltLevel == 2'b00, "R1 level in reset", int'(mltLevel), 0);
    chk(nibbleAck == 1'b0, "R1 ack in reset", int'(nibbleAck), 0);
    txEn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk(mltLevel == 2'b00, "R1 level after release", int'(mltLevel), 0);
  endtask

  task automatic testIdle();
    int m0 = mism;
    int changes = 0;
    logic [1:0] prev = mltLevel;
    repeat (100) begin
      @(negedge clk);
      if (mltLevel != prev) changes++;
      prev = mltLevel;
    end
    chk(mism == m0, "R2 R7 R9 R10 idle stream mismatches", mism - m0, 0);
    chk(changes > 0, "R8 idle line activity", changes, 1);
  endtask

  task automatic testFrame();
    int m0 = mism;
    int a0 = ackCnt;
    sendFrame(16, 0, 1, 1'b0, 1'b0);
    drain();
    chk(mism == m0, "R3 R4 R6 frame stream mismatches", mism - m0, 0);
    chk(ackCnt - a0 == 16, "R12 ack count", ackCnt - a0, 16);
  endtask

  task automatic testJunk();
    int m0 = mism;
    int a0 = ackCnt;
    sendFrame(6, 9, 7, 1'b0, 1'b1);
    drain();
    chk(mism == m0, "R12 txData between samples ignored", mism - m0, 0);
    chk(ackCnt - a0 == 6, "R12 ack count with junk", ackCnt - a0, 6);
  endtask

  task automatic testBackToBack();
    int m0 = mism;
    int a0 = ackCnt;
    sendFrame(3, 5, 3, 1'b0, 1'b0);
    waitBoundary();
    sendFrame(4, 12, 1, 1'b1, 1'b0);
    drain();
    chk(mism == m0, "R5 end pair and idle gap", mism - m0, 0);
    chk(ackCnt - a0 == 7, "R5 ack count over two frames", ackCnt - a0, 7);
  endtask

  task automatic testStall();
    int m0 = mism;
    int s0 = stallErr;
    enMode = 1;
    sendFrame(5, 2, 5, 1'b0, 1'b0);
    drain();
    enMode = 0;
    repeat (2) @(negedge clk);
    chk(mism == m0, "R11 stream with enable gaps", mism - m0, 0);
    chk(stallErr == s0, "R11 level held on disabled cycles", stallErr - s0, 0);
  endtask

  task automatic testPorts();
    logic [1:0] seqA [50];
    int diff = 0;
    int m0 = mism;
    doReset(5'd0);
    for (int i = 0; i < 50; i++) begin @(negedge clk); seqA[i] = mltLevel; end
    doReset(5'd1);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mltLevel != seqA[i]) diff++;
    end
    chk(diff > 0, "R8 distinct sequences per address", diff, 1);
    chk(mism == m0, "R8 seed mapping matches", mism - m0, 0);
  endtask

  initial begin
    testReset();
    testIdle();
    testFrame();
    testJunk();
    testBackToBack();
    testStall();
    testPorts();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule